// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block counts down a programmed interval of whole seconds and raises an alarm when the interval runs out. Software loads a 32-bit interval, sets the run enable, and the remaining count drops by one on every one-second tick pulse. When the count moves from one to zero, a sticky pending flag is set. The flag stays set until software clears it by writing a one to it.

Two outputs are derived from the pending flag. Each has its own enable: an interrupt request and a wake-up request for the power controller. The remaining count can be read back at any time. Writing the interval register replaces the remaining count at once. Writing zero to it cancels an armed interval without raising the alarm.

The register port is a simple single-cycle write port and a combinational read port. Both use word addresses: 0 interval, 1 remaining count (read-only), 2 run enable, 3 interrupt enable, 4 pending status, 5 wake-up enable. Addresses 6 and 7 are unmapped.

Top module: `secs_countdown_alarm`

## Requirements
- R1: After reset the remaining count, the stored interval, all three enables and the pending flag are zero, and irq and wake are low.
- R2: A write to address 0 takes effect on the next clock. The remaining count (read at address 1) then equals the written value, and address 0 reads back the last written interval.
- R3: On a cycle with sec_tick high, run enable set (bit 0 at address 2) and a remaining count above zero, the count drops by one. A tick with run enable clear leaves the count unchanged.
- R4: The tick that moves the count from 1 to 0 sets the pending flag, which reads as bit 0 at address 4. Once the count is zero it stays zero until reloaded. A zero count never sets the flag.
- R5: A write to address 4 with bit 0 high clears the pending flag. A write there with bit 0 low leaves it unchanged.
- R6: If a clearing write and an expiry fall in the same cycle, the pending flag is set after that cycle.
- R7: irq is high exactly when the pending flag and the interrupt enable (bit 0 at address 3) are both set.
- R8: wake is high exactly when the pending flag and the wake-up enable (bit 0 at address 5) are both set.
- R9: A write to address 0 in the same cycle as an active tick wins. The remaining count becomes the written value, with no decrement and no expiry.
- R10: Addresses 6 and 7 read as zero. The enable and status registers keep only bit 0, and their upper read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Some properties are checked on every cycle:
- The count never changes without a tick or a reload, and stays at zero until reloaded.
- A reload lands on the next clock.
- The pending flag rises only on a 1-to-0 step, and clears after a clearing write with no expiry.
- An expiry always leaves the flag set.
- irq and wake never assert without the pending flag.

Other behaviour only the bench scenarios can show:
- Exact end-to-end countdown lengths.
- A tick colliding with a reload, and a clearing write colliding with an expiry.
- Read-back of each address, and gating by each enable under long random traffic.

// File: rtl/cdal_pkg.sv
package cdal_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_INTERVAL = 3'd0,
        A_REMAIN   = 3'd1,
        A_RUN      = 3'd2,
        A_IRQEN    = 3'd3,
        A_STATUS   = 3'd4,
        A_WAKEEN   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic run;
        logic irq_en;
        logic wake_en;
        logic pending;
    } ctrl_state_t;
endpackage

// File: rtl/cdal_counter.sv
module cdal_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remain,
    output logic [CNT_W-1:0] interval,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] ivl;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d   = st_q;
        step   = tick && run && (st_q.rem != '0);
        expire = step && !load_en && (st_q.rem == ONE);
        if (load_en) begin
            st_d.rem = load_val;
            st_d.ivl = load_val;
        end else if (step) begin
            st_d.rem = st_q.rem - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign remain   = st_q.rem;
    assign interval = st_q.ivl;
endmodule

// File: rtl/cdal_ctrl.sv
module cdal_ctrl
    import cdal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit0,
    input  logic              expire,
    output ctrl_state_t       ctrl
);
    ctrl_state_t cs_d, cs_q;
    logic        clr;

    always_comb begin
        cs_d = cs_q;
        clr  = wr_en && (wr_addr == A_STATUS) && wr_bit0;
        if (wr_en) begin
            case (wr_addr)
                A_RUN:    cs_d.run     = wr_bit0;
                A_IRQEN:  cs_d.irq_en  = wr_bit0;
                A_WAKEEN: cs_d.wake_en = wr_bit0;
                default:  ;
            endcase
        end
        cs_d.pending = expire || (cs_q.pending && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign ctrl = cs_q;
endmodule

// File: rtl/cdal_rdmux.sv
module cdal_rdmux
    import cdal_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  remain,
    input  logic [CNT_W-1:0]  interval,
    input  ctrl_state_t       ctrl,
    output logic [CNT_W-1:0]  rd_data
);
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_INTERVAL: rd_data = interval;
            A_REMAIN:   rd_data = remain;
            A_RUN:      rd_data[0] = ctrl.run;
            A_IRQEN:    rd_data[0] = ctrl.irq_en;
            A_STATUS:   rd_data[0] = ctrl.pending;
            A_WAKEEN:   rd_data[0] = ctrl.wake_en;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/secs_countdown_alarm.sv
module secs_countdown_alarm
    import cdal_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq,
    output logic              wake
);
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] interval;
    logic             expire;
    logic             load_en;
    ctrl_state_t      ctrl;

    assign load_en = wr_en && (wr_addr == A_INTERVAL);

    cdal_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .run      (ctrl.run),
        .load_en  (load_en),
        .load_val (wr_data),
        .remain   (remain),
        .interval (interval),
        .expire   (expire)
    );

    cdal_ctrl ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit0 (wr_data[0]),
        .expire  (expire),
        .ctrl    (ctrl)
    );

    cdal_rdmux #(.CNT_W(CNT_W)) rdmux_i (
        .rd_addr  (rd_addr),
        .remain   (remain),
        .interval (interval),
        .ctrl     (ctrl),
        .rd_data  (rd_data)
    );

    assign irq  = ctrl.pending && ctrl.irq_en;
    assign wake = ctrl.pending && ctrl.wake_en;
endmodule

// File: rtl/cdal_checker.sv
module cdal_checker
    import cdal_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [CNT_W-1:0]  remain,
    input logic              expire,
    input logic              run,
    input logic              pending,
    input logic              irq,
    input logic              wake
);
    logic load_w;
    logic clr_w;
    assign load_w = wr_en && (wr_addr == A_INTERVAL);
    assign clr_w  = wr_en && (wr_addr == A_STATUS) && wr_data[0];

    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> (remain == $past(wr_data)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_w && !(sec_tick && run)) |=> (remain == $past(remain)));

    assert_zero_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == '0 && !load_w) |=> (remain == '0 && !$rose(pending)));

    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(remain) == CNT_W'(1) && remain == '0));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !expire) |=> !pending);

    assert_expiry_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending);

    assert_wake_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> pending);
endmodule

bind secs_countdown_alarm cdal_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .remain   (remain),
    .expire   (expire),
    .run      (ctrl.run),
    .pending  (ctrl.pending),
    .irq      (irq),
    .wake     (wake)
);

// File: tb/secs_countdown_alarm_tb_top.sv
module secs_countdown_alarm_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sec_tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         irq, wake;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [W-1:0] m_ivl = '0, m_rem = '0;
    logic m_run = 0, m_ie = 0, m_wk = 0, m_pend = 0;

    always #4 clk = ~clk;

    secs_countdown_alarm #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .wake(wake)
    );

    function automatic logic [W-1:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ivl;
            3'd1: return m_rem;
            3'd2: return {31'b0, m_run};
            3'd3: return {31'b0, m_ie};
            3'd4: return {31'b0, m_pend};
            3'd5: return {31'b0, m_wk};
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle at negedge, clock it, update model, return at next negedge
    task automatic step(input logic t, input logic we, input logic [2:0] a, input logic [W-1:0] d);
        logic load, clr, ex, st;
        logic [W-1:0] nrem;
        sec_tick = t; wr_en = we; wr_addr = a; wr_data = d;
        load = we && a == 3'd0;
        clr  = we && a == 3'd4 && d[0];
        st   = t && m_run && m_rem != 0;
        ex   = st && !load && m_rem == 1;
        nrem = load ? d : (st ? m_rem - 1 : m_rem);
        @(posedge clk);
        m_rem  = nrem;
        if (load) m_ivl = d;
        m_pend = ex || (m_pend && !clr);
        if (we && a == 3'd2) m_run = d[0];
        if (we && a == 3'd3) m_ie  = d[0];
        if (we && a == 3'd5) m_wk  = d[0];
        @(negedge clk);
        sec_tick = 0; wr_en = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [W-1:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin peek(3'(a), v); chk("R1 reg", v, '0); end
        chk("R1 irq", {31'b0, irq}, '0);
        chk("R1 wake", {31'b0, wake}, '0);

        // R2 load
        step(0, 1, 3'd0, 32'd5);
        peek(3'd1, v); chk("R2 remain", v, 32'd5);
        peek(3'd0, v); chk("R2 interval", v, 32'd5);
        // R3 tick without run
        step(1, 0, 0, 0);
        peek(3'd1, v); chk("R3 no run", v, 32'd5);
        step(0, 1, 3'd2, 32'd1);
        step(0, 1, 3'd3, 32'd1);
        step(1, 0, 0, 0);
        peek(3'd1, v); chk("R3 decrement", v, 32'd4);
        step(0, 0, 0, 0);
        peek(3'd1, v); chk("R3 no tick", v, 32'd4);
        repeat (3) step(1, 0, 0, 0);
        peek(3'd4, v); chk("R4 not yet", v, 32'd0);
        step(1, 0, 0, 0);
        peek(3'd1, v); chk("R4 zero", v, 32'd0);
        peek(3'd4, v); chk("R4 pending", v, 32'd1);
        chk("R7 irq on", {31'b0, irq}, 32'd1);
        chk("R8 wake off", {31'b0, wake}, 32'd0);
        repeat (3) step(1, 0, 0, 0);
        peek(3'd1, v); chk("R4 stays zero", v, 32'd0);
        step(0, 1, 3'd5, 32'd1);
        chk("R8 wake on", {31'b0, wake}, 32'd1);
        step(0, 1, 3'd4, 32'd0);
        peek(3'd4, v); chk("R5 write zero keeps", v, 32'd1);
        step(0, 1, 3'd4, 32'd1);
        peek(3'd4, v); chk("R5 cleared", v, 32'd0);
        chk("R7 irq off", {31'b0, irq}, 32'd0);
        // R4 zero load never fires
        step(0, 1, 3'd0, 32'd0);
        repeat (2) step(1, 0, 0, 0);
        peek(3'd4, v); chk("R4 zero load", v, 32'd0);
        // R9 load with tick
        step(0, 1, 3'd0, 32'd2);
        step(1, 1, 3'd0, 32'd1);
        peek(3'd1, v); chk("R9 load wins", v, 32'd1);
        peek(3'd4, v); chk("R9 no expiry", v, 32'd0);
        // R6 clear and expiry together
        step(1, 1, 3'd4, 32'd1);
        peek(3'd4, v); chk("R6 expiry wins", v, 32'd1);
        // R10
        peek(3'd6, v); chk("R10 addr6", v, 32'd0);
        peek(3'd7, v); chk("R10 addr7", v, 32'd0);
        step(0, 1, 3'd3, 32'hFFFF_FFFF);
        peek(3'd3, v); chk("R10 bit0 only", v, 32'd1);
        step(0, 1, 3'd3, 32'hFFFF_FFFE);
        peek(3'd3, v); chk("R10 bit0 clear", v, 32'd0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            logic [W-1:0] d;
            logic [2:0] ra;
            a  = 3'($urandom_range(0, 7));
            d  = (a == 3'd0) ? W'($urandom_range(0, 6)) : W'($urandom);
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0), a, d);
            ra = 3'($urandom_range(0, 7));
            peek(ra, v);
            chk("R2/R3/R4 random read", v, exp_rd(ra));
            chk("R7 random irq", {31'b0, irq}, {31'b0, m_pend && m_ie});
            chk("R8 random wake", {31'b0, wake}, {31'b0, m_pend && m_wk});
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule